// File: doc/BRIEF.md
# Vector mask compress and expand unit

This unit rearranges the elements of one vector register under the control of a per-element mask. There is one mask bit for each element. In compress mode, the elements whose mask bit is set are packed in their original order into the lowest destination positions. In expand mode, the operation runs the other way: successive source elements land in the positions whose mask bit is set. In both modes the unit reports how many mask bits were set among the active elements.

A caller presents the source vector, the prior destination contents, the mask, a vector length and the mode, then pulses `start_i`. The unit captures all operands on that edge and walks the active elements one per cycle. It uses a read pointer and a write pointer. It then pulses `done_o`. The result stays on `dst_o` and `len_o` until the next accepted start. Elements at or beyond the vector length take no part.

Top module: `vmask_perm`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, and `dst_o` and `len_o` are all zero.
- R2: With `mode_i`=0 (compress), the active elements whose mask bit is set appear at destination positions 0, 1, 2 and so on, in ascending source index order.
- R3: `len_o` at completion equals the number of set mask bits among the active elements, in both modes.
- R4: In compress mode, destination positions at and above `len_o` keep the `dst_i` value captured at start.
- R5: With `mode_i`=1 (expand), the k-th set mask position (counting from element 0, k from 0) receives source element k.
- R6: In expand mode, positions whose mask bit is clear keep the captured `dst_i` value.
- R7: Only elements 0 to VL-1 are active, where VL is `vl_i` clamped to N. Mask bits at or beyond VL are ignored, and positions at or beyond VL that no active element writes keep their captured value.
- R8: `done_o` is a one-cycle pulse that is high in the cycle after the VL-th clock edge following the start edge (with VL=0, the cycle right after the start edge). `busy_o` is high while elements are being processed and is never high together with `done_o`.
- R9: `start_i` is ignored while `busy_o` is high. The running operation completes on its own operands.
- R10: An all-zero mask gives `len_o`=0 and a destination equal to the captured `dst_i`.
- R11: `dst_o` and `len_o` hold their values from completion until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; accepted when `busy_o` is low |
| mode_i | input | 1 | 0 = compress, 1 = expand |
| vl_i | input | $clog2(N+1) | Vector length; values above N act as N |
| mask_i | input | N | One mask bit per element; bit i belongs to element i |
| src_i | input | N*W | Source vector; element i in bits [i*W +: W] |
| dst_i | input | N*W | Prior destination contents, same layout |
| busy_o | output | 1 | Elements are being processed |
| done_o | output | 1 | One-cycle completion pulse |
| dst_o | output | N*W | Result vector, same layout |
| len_o | output | $clog2(N+1) | Count of set active mask bits |

## Verification
Sparse, dense, all-ones and all-zero masks are applied in both modes. Comparing packed positions against untouched positions separates ordering faults from pointer faults. Short vector lengths with mask bits set beyond them show whether the length limit is honoured. An over-range length and a zero length exercise the clamp and the empty walk. A second start pulse issued with different operands in the middle of a run shows whether the operands were captured once and later pulses were refused. The completion latency is measured on every operation, which catches a read pointer that stops early or late.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
  typedef enum logic {
    VMP_COMPRESS = 1'b0,
    VMP_EXPAND   = 1'b1
  } vmp_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } vmp_state_e;
endpackage

// File: rtl/vmp_ctrl.sv
module vmp_ctrl
  import vmp_pkg::*;
#(
  parameter int N  = 8,
  localparam int CW = $clog2(N + 1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] vl_i,
  output logic          load_o,
  output logic          step_o,
  output logic [IW-1:0] rd_idx_o,
  output logic          busy_o,
  output logic          done_o
);
  vmp_state_e    state_q;
  logic [CW-1:0] rd_q, vl_q, vl_eff;

  assign vl_eff   = (vl_i > CW'(N)) ? CW'(N) : vl_i;
  assign load_o   = start_i && (state_q != ST_RUN);
  assign step_o   = (state_q == ST_RUN);
  assign busy_o   = step_o;
  assign done_o   = (state_q == ST_FIN);
  assign rd_idx_o = rd_q[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rd_q    <= '0;
      vl_q    <= '0;
    end else if (load_o) begin
      rd_q    <= '0;
      vl_q    <= vl_eff;
      state_q <= (vl_eff == '0) ? ST_FIN : ST_RUN;
    end else begin
      case (state_q)
        ST_RUN: begin
          rd_q <= rd_q + 1'b1;
          if (rd_q == vl_q - 1'b1) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vmp_datapath.sv
module vmp_datapath
  import vmp_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 16,
  localparam int CW = $clog2(N + 1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          mode_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N*W-1:0] src_i,
  input  logic [N*W-1:0] dst_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [N*W-1:0] dst_o,
  output logic [CW-1:0] len_o
);
  vmp_mode_e     mode_q;
  logic [N-1:0]  mask_q;
  logic [W-1:0]  src_q [N];
  logic [W-1:0]  dst_q [N];
  logic [CW-1:0] wr_q;
  logic [IW-1:0] wr_idx;

  assign wr_idx = wr_q[IW-1:0];
  assign len_o  = wr_q;

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign dst_o[g*W +: W] = dst_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= VMP_COMPRESS;
      mask_q <= '0;
      wr_q   <= '0;
      for (int i = 0; i < N; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else if (load_i) begin
      mode_q <= vmp_mode_e'(mode_i);
      mask_q <= mask_i;
      wr_q   <= '0;
      for (int i = 0; i < N; i++) begin
        src_q[i] <= src_i[i*W +: W];
        dst_q[i] <= dst_i[i*W +: W];
      end
    end else if (step_i && mask_q[rd_idx_i]) begin
      wr_q <= wr_q + 1'b1;
      if (mode_q == VMP_COMPRESS) dst_q[wr_idx]   <= src_q[rd_idx_i];
      else                        dst_q[rd_idx_i] <= src_q[wr_idx];
    end
  end
endmodule

// File: rtl/vmask_perm.sv
module vmask_perm #(
  parameter int N  = 8,
  parameter int W  = 16,
  localparam int CW = $clog2(N + 1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           mode_i,
  input  logic [CW-1:0]  vl_i,
  input  logic [N-1:0]   mask_i,
  input  logic [N*W-1:0] src_i,
  input  logic [N*W-1:0] dst_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N*W-1:0] dst_o,
  output logic [CW-1:0]  len_o
);
  logic          load, step;
  logic [IW-1:0] rd_idx;

  vmp_ctrl #(.N(N)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .vl_i     (vl_i),
    .load_o   (load),
    .step_o   (step),
    .rd_idx_o (rd_idx),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  vmp_datapath #(.N(N), .W(W)) i_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .mode_i   (mode_i),
    .mask_i   (mask_i),
    .src_i    (src_i),
    .dst_i    (dst_i),
    .rd_idx_i (rd_idx),
    .dst_o    (dst_o),
    .len_o    (len_o)
  );
endmodule

// File: rtl/vmask_perm_chk.sv
module vmask_perm_chk #(
  parameter int N  = 8,
  parameter int W  = 16,
  localparam int CW = $clog2(N + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           mode_i,
  input logic [CW-1:0]  vl_i,
  input logic [N-1:0]   mask_i,
  input logic [N*W-1:0] src_i,
  input logic [N*W-1:0] dst_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [N*W-1:0] dst_o,
  input logic [CW-1:0]  len_o
);
  logic [CW-1:0] chk_vl, chk_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_vl  <= '0;
      chk_cnt <= '0;
    end else if (start_i && !busy_o) begin
      chk_vl  <= (vl_i > CW'(N)) ? CW'(N) : vl_i;
      chk_cnt <= '0;
    end else if (busy_o) begin
      chk_cnt <= chk_cnt + 1'b1;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

  // R8
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (chk_cnt == chk_vl));

  // R8
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R3
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o <= chk_vl));

  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o && !$past(start_i)) |-> ($stable(dst_o) && $stable(len_o)));
endmodule

bind vmask_perm vmask_perm_chk #(.N(N), .W(W)) i_vmask_perm_chk (.*);

// File: tb/test_vmask_perm.sv
module test_vmask_perm;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int CW = $clog2(N + 1);

  typedef struct {
    logic [N*W-1:0] dst;
    logic [CW-1:0]  len;
    int             lat;
    int             c0;
    string          tag;
  } exp_t;

  logic           clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, mode_i = 1'b0;
  logic [CW-1:0]  vl_i = '0;
  logic [N-1:0]   mask_i = '0;
  logic [N*W-1:0] src_i = '0, dst_i = '0;
  logic           busy_o, done_o;
  logic [N*W-1:0] dst_o;
  logic [CW-1:0]  len_o;

  int   checks = 0, errors = 0, cyc = 0;
  exp_t sb_q[$];

  vmask_perm #(.N(N), .W(W)) i_vmask_perm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .vl_i(vl_i), .mask_i(mask_i), .src_i(src_i), .dst_i(dst_i),
    .busy_o(busy_o), .done_o(done_o), .dst_o(dst_o), .len_o(len_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] mk_vec(input logic [W-1:0] base);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = base + W'(i);
    return v;
  endfunction

  task automatic run_op(input logic md, input int vl, input logic [N-1:0] m,
                        input logic [N*W-1:0] s, input logic [N*W-1:0] d,
                        input string tag, input bit glitch);
    exp_t e;
    int   vle, k;
    vle = (vl > N) ? N : vl;
    e.dst = d;
    k = 0;
    for (int i = 0; i < vle; i++) begin
      if (m[i]) begin
        if (md == 1'b0) e.dst[k*W +: W] = s[i*W +: W];
        else            e.dst[i*W +: W] = s[k*W +: W];
        k++;
      end
    end
    e.len = CW'(k);
    e.lat = vle + 1;
    e.tag = tag;
    @(negedge clk_i);
    mode_i = md; vl_i = CW'(vl); mask_i = m; src_i = s; dst_i = d; start_i = 1'b1;
    e.c0 = cyc;
    sb_q.push_back(e);
    @(negedge clk_i);
    start_i = 1'b0;
    if (glitch) begin
      // R9: second start while busy, different operands
      @(negedge clk_i);
      mode_i = ~md; vl_i = CW'(1); mask_i = ~m; src_i = ~s; dst_i = ~d; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    // R11: result held after completion
    check(dst_o == e.dst && len_o == e.len && !busy_o, {"R11 hold ", tag}, dst_o, e.dst);
  endtask

  // monitor: pop expected item on each completion pulse
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R8 unexpected done", '0, '0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(dst_o == e.dst, {"dst ", e.tag}, dst_o, e.dst);
        check(len_o == e.len, {"R3 len ", e.tag}, N*W'(len_o), N*W'(e.len));
        check(cyc - e.c0 == e.lat, {"R8 latency ", e.tag},
              N*W'(cyc - e.c0), N*W'(e.lat));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    check(1'b0, "watchdog expired", '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!busy_o && !done_o && dst_o == '0 && len_o == '0, "R1 reset", dst_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_op(1'b0, 8, 8'b1011_0010, mk_vec(16'h1100), mk_vec(16'hD000), "R2 R4 compress sparse", 1'b0);
    run_op(1'b1, 8, 8'b0110_1001, mk_vec(16'h2200), mk_vec(16'hD100), "R5 R6 expand sparse", 1'b0);
    run_op(1'b0, 5, 8'hFF, mk_vec(16'h3300), mk_vec(16'hD200), "R7 compress short vl", 1'b0);
    run_op(1'b1, 3, 8'b1111_1010, mk_vec(16'h4400), mk_vec(16'hD300), "R7 expand short vl", 1'b0);
    run_op(1'b0, 8, 8'h00, mk_vec(16'h5500), mk_vec(16'hD400), "R10 compress zero mask", 1'b0);
    run_op(1'b1, 8, 8'h00, mk_vec(16'h6600), mk_vec(16'hD500), "R10 expand zero mask", 1'b0);
    run_op(1'b0, 0, 8'hFF, mk_vec(16'h7700), mk_vec(16'hD600), "R8 zero vl", 1'b0);
    run_op(1'b0, 15, 8'hA5, mk_vec(16'h8800), mk_vec(16'hD700), "R7 clamp vl", 1'b0);
    run_op(1'b0, 8, 8'b1100_0110, mk_vec(16'h9900), mk_vec(16'hD800), "R9 start while busy", 1'b1);
    run_op(1'b1, 8, 8'hFF, mk_vec(16'hAA00), mk_vec(16'hD900), "R5 expand full mask", 1'b0);
    run_op(1'b0, 8, 8'hFF, mk_vec(16'hBB00), mk_vec(16'hDA00), "R2 compress full mask", 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule